// File: doc/BRIEF.md
# Low-Transition Scan Test Pattern Generator

This block produces stimulus for the parallel scan chains of a logic self-test. An internal linear feedback shift register (LFSR) holds a seed. A twisted-ring (Johnson) counter of the same width steps once for each vector. Each vector is the bitwise XOR of the seed and the current Johnson state. The seed moves on only after a complete Johnson cycle of 2l states. Because only one Johnson bit flips per vector, neighbouring vectors differ in one position, which keeps scan switching low. A fixed broadcast network then fans each generated chain bit out to four scan-chain inputs, so the generator drives 4m chains from m bits of state.

A run begins on a `start` pulse and stops after the number of vectors held in `test_len`. Vectors leave on a valid/ready stream. A vector counts as delivered only on a cycle where both `chain_valid` and `chain_ready` are high. While the consumer holds `chain_ready` low, the offered vector and `chain_valid` stay unchanged and no internal state moves. The seed update takes a single bubble cycle with `chain_valid` low, on the cycle after the last vector of each Johnson cycle. The whole block runs on one clock. The slow seed rate is an internal enable, not a second clock.

Top module: `lt_scan_tpg`

## Requirements
- R1: While reset is applied and after it is released, `chain_valid` and `done` are low until a run is started.
- R2: A `start` pulse while idle reloads the seed with SEED_INIT (default 8'hA5) and clears the Johnson state to all zeros. The first vector is offered in the following cycle. `test_len` is captured at that pulse.
- R3: The Johnson state steps once per delivered vector, as next = {j[l-2:0], ~j[l-1]}, where bit 0 is the LSB. It returns to all zeros after 2l steps.
- R4: The seed is an m-stage Fibonacci LFSR, next = {s[m-2:0], ^(s & TAPS)}, with TAPS = 8'hB8 for m = 8. It advances once after every 2l delivered vectors of a run. During that update cycle `chain_valid` is low for exactly one cycle.
- R5: The generated chain bits are seed XOR Johnson state, aligned by position (l = m).
- R6: The broadcast output is chain_data[4i+k] = gen[i] XOR BC_MASK[k] for k = 0..3, with BC_MASK defaulting to 4'b0110.
- R7: While `chain_valid` is high and `chain_ready` is low, `chain_valid` stays high and `chain_data` stays unchanged on the next cycle.
- R8: `done` rises in the cycle after the delivery of vector number `test_len`. From then on `chain_valid` stays low. `done` stays high until the next accepted `start`.
- R9: A `start` with `test_len` of zero sets `done` in the next cycle and offers no vector.
- R10: A `start` pulse during a run is ignored. The vector sequence continues without a restart.
- R11: A new run after `done` repeats the same vector sequence from the initial seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a run when idle |
| test_len | input | CNT_W | Number of vectors for the run |
| chain_data | output | 4*CH_W | Scan-chain input bits |
| chain_valid | output | 1 | Vector on chain_data is offered |
| chain_ready | input | 1 | Consumer accepts the offered vector |
| done | output | 1 | Run finished |

## Verification
The hardest case to reach is a seed update that meets consumer back-pressure, or a run that ends exactly on a Johnson-cycle boundary. In the first case a stall just before or after the bubble could shift the seed timing. In the second the seed must not advance at all. The stimulus runs lengths of exactly 2l, 2l+1 and several cycles long. It combines them with repeating ready patterns whose period differs from 2l, so stalls fall on every position in the cycle, including next to the bubble. A start pulse is also injected in the middle of a stalled run.

// File: rtl/lt_tpg_pkg.sv
package lt_tpg_pkg;

  // Tap mask of a maximal-length Fibonacci LFSR for a given width.
  function automatic logic [15:0] lfsr_taps(input int w);
    logic [15:0] t;
    case (w)
      3:       t = 16'h0006;
      4:       t = 16'h000C;
      5:       t = 16'h0014;
      6:       t = 16'h0030;
      7:       t = 16'h0060;
      8:       t = 16'h00B8;
      9:       t = 16'h0110;
      10:      t = 16'h0240;
      11:      t = 16'h0500;
      12:      t = 16'h0829;
      13:      t = 16'h100D;
      14:      t = 16'h2015;
      15:      t = 16'h6000;
      default: t = 16'hD008;
    endcase
    return t;
  endfunction

endpackage

// File: rtl/lt_tpg_seed_lfsr.sv
module lt_tpg_seed_lfsr #(
  parameter int          W    = 8,
  parameter logic [W-1:0] INIT = 'hA5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  output logic [W-1:0] q
);
  localparam logic [15:0]  TAPS16 = lt_tpg_pkg::lfsr_taps(W);
  localparam logic [W-1:0] TAPS   = TAPS16[W-1:0];

  logic fb;
  assign fb = ^(q & TAPS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= INIT;
    else if (load) q <= INIT;
    else if (step) q <= {q[W-2:0], fb};
  end
endmodule

// File: rtl/lt_tpg_johnson.sv
module lt_tpg_johnson #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  output logic [W-1:0] q,
  output logic         last
);
  localparam logic [W-1:0] LAST_ST = {1'b1, {(W-1){1'b0}}};

  // The final state of a cycle has only the top bit set.
  assign last = (q == LAST_ST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (clr)  q <= '0;
    else if (step) q <= {q[W-2:0], ~q[W-1]};
  end
endmodule

// File: rtl/lt_tpg_bcast.sv
module lt_tpg_bcast #(
  parameter int         W    = 8,
  parameter logic [3:0] MASK = 4'b0110
) (
  input  logic [W-1:0]   gen,
  output logic [4*W-1:0] fan
);
  for (genvar i = 0; i < W; i++) begin : g_chain
    for (genvar k = 0; k < 4; k++) begin : g_copy
      assign fan[4*i+k] = gen[i] ^ MASK[k];
    end
  end
endmodule

// File: rtl/lt_scan_tpg.sv
module lt_scan_tpg #(
  parameter int             CH_W      = 8,
  parameter int             CNT_W     = 16,
  parameter logic [CH_W-1:0] SEED_INIT = 'hA5,
  parameter logic [3:0]     BC_MASK   = 4'b0110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  test_len,
  output logic [4*CH_W-1:0] chain_data,
  output logic              chain_valid,
  input  logic              chain_ready,
  output logic              done
);
  logic             run_q, sstep_q, done_q;
  logic [CNT_W-1:0] cnt_q, len_q, cnt_nxt;
  logic [CH_W-1:0]  seed_q, john_q, gen;
  logic             jlast, go, acc, hit;

  assign go      = start & ~run_q;
  assign chain_valid = run_q & ~sstep_q;
  assign acc     = chain_valid & chain_ready;
  assign cnt_nxt = cnt_q + 1'b1;
  assign hit     = (cnt_nxt == len_q);
  assign done    = done_q;

  lt_tpg_seed_lfsr #(.W(CH_W), .INIT(SEED_INIT)) u_seed (
    .clk(clk), .rst_n(rst_n), .load(go), .step(sstep_q), .q(seed_q)
  );

  lt_tpg_johnson #(.W(CH_W)) u_john (
    .clk(clk), .rst_n(rst_n), .clr(go), .step(acc), .q(john_q), .last(jlast)
  );

  assign gen = seed_q ^ john_q;

  lt_tpg_bcast #(.W(CH_W), .MASK(BC_MASK)) u_bcast (
    .gen(gen), .fan(chain_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      sstep_q <= 1'b0;
      done_q  <= 1'b0;
      cnt_q   <= '0;
      len_q   <= '0;
    end else if (go) begin
      run_q   <= (test_len != '0);
      done_q  <= (test_len == '0);
      sstep_q <= 1'b0;
      cnt_q   <= '0;
      len_q   <= test_len;
    end else begin
      sstep_q <= acc & jlast & ~hit;
      if (acc) begin
        cnt_q <= cnt_nxt;
        if (hit) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lt_tpg_chk.sv
module lt_tpg_chk #(
  parameter int CH_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              run,
  input logic              valid,
  input logic              ready,
  input logic              done,
  input logic [4*CH_W-1:0] data,
  input logic [CH_W-1:0]   seed,
  input logic [CH_W-1:0]   john
);
  localparam int TWO_L = 2 * CH_W;
  localparam int KW    = $clog2(TWO_L + 1) + 1;

  logic          go, acc;
  logic [KW-1:0] k_q;
  assign go  = start & ~run;
  assign acc = valid & ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   k_q <= '0;
    else if (go)  k_q <= '0;
    else if (acc) k_q <= (k_q == KW'(TWO_L)) ? KW'(1) : k_q + 1'b1;
  end

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !valid && !done); // R1

  AST_JOHN_ONE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(go) |-> $countones(john ^ $past(john)) <= 1); // R3

  AST_SEED_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (seed != $past(seed)) && !$past(go) |-> k_q == KW'(TWO_L)); // R4

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !ready && !start |=> valid && $stable(data)); // R7

  AST_NO_VALID_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !valid); // R8
endmodule

bind lt_scan_tpg lt_tpg_chk #(.CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .run(run_q),
  .valid(chain_valid), .ready(chain_ready), .done(done),
  .data(chain_data), .seed(seed_q), .john(john_q)
);

// File: tb/test_lt_scan_tpg.sv
module test_lt_scan_tpg;
  localparam int        CH_W  = 8;
  localparam int        CNT_W = 16;
  localparam logic [7:0] SEED0 = 8'hA5;
  localparam logic [7:0] TAPS  = 8'hB8;
  localparam logic [3:0] BCM   = 4'b0110;

  // {test_len, ready pattern, cycle of injected start (0 = none)}
  localparam int NCASE = 6;
  localparam logic [31:0] CASES [NCASE] = '{
    {16'd40, 8'hFF, 8'd0},
    {16'd16, 8'hFF, 8'd0},
    {16'd17, 8'hFF, 8'd0},
    {16'd50, 8'b10110010, 8'd0},
    {16'd35, 8'b01010101, 8'd9},
    {16'd60, 8'b11101110, 8'd0}
  };

  logic clk = 0, rst_n = 0, start = 0, chain_ready = 0;
  logic [CNT_W-1:0]  test_len = '0;
  logic [4*CH_W-1:0] chain_data;
  logic              chain_valid, done;
  int n_chk = 0, n_bad = 0, cyc = 0;

  always #2 clk = ~clk;

  lt_scan_tpg i_lt_scan_tpg (
    .clk(clk), .rst_n(rst_n), .start(start), .test_len(test_len),
    .chain_data(chain_data), .chain_valid(chain_valid),
    .chain_ready(chain_ready), .done(done)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [4*CH_W-1:0] fanout(input logic [CH_W-1:0] s, input logic [CH_W-1:0] j);
    logic [4*CH_W-1:0] r;
    for (int i = 0; i < CH_W; i++)
      for (int k = 0; k < 4; k++) r[4*i+k] = s[i] ^ j[i] ^ BCM[k];
    return r;
  endfunction

  // Reference: one run, vectors compared as offered.
  task automatic run_case(input int len, input logic [7:0] pat, input int inj);
    logic [7:0] ms = SEED0, mj = '0;
    logic [4*CH_W-1:0] prev = '0;
    int acc_n = 0, in_cyc = 0, t = 0, bubbles = 0;
    bit stalled = 0, fin = 0;
    @(negedge clk); start = 1; test_len = CNT_W'(len); chain_ready = 0;
    @(negedge clk); start = 0;
    while (!fin && t < 4000) begin
      if (done) begin
        check(acc_n == len, "R8 done after test_len vectors", 64'(acc_n), 64'(len));
        check(bubbles == (len > 0 ? (len - 1) / (2*CH_W) : 0), "R4 bubble count",
              64'(bubbles), 64'(len > 0 ? (len - 1) / (2*CH_W) : 0));
        fin = 1;
      end else if (chain_valid) begin
        if (stalled) check(chain_data == prev, "R7 data held on stall", 64'(chain_data), 64'(prev));
        check(chain_data == fanout(ms, mj), "R5 R6 vector value", 64'(chain_data), 64'(fanout(ms, mj)));
        prev = chain_data;
        chain_ready = pat[t % 8];
        stalled = !chain_ready;
        if (chain_ready) begin
          acc_n++; in_cyc++;
          mj = {mj[CH_W-2:0], ~mj[CH_W-1]};
          if (in_cyc == 2*CH_W) begin
            in_cyc = 0;
            ms = {ms[CH_W-2:0], ^(ms & TAPS)};
          end
        end
      end else begin
        bubbles++;
        check(in_cyc == 0 && acc_n > 0, "R4 bubble only after full Johnson cycle",
              64'(in_cyc), 64'd0);
        chain_ready = pat[t % 8];
      end
      start = (inj != 0 && t == inj); // R10: ignored mid-run start
      t++;
      if (!fin) @(negedge clk);
    end
    if (!fin) check(0, "R8 run finished", 64'(t), 64'(len));
    start = 0;
    @(negedge clk);
    check(done && !chain_valid, "R8 done sticky, no valid", {done, chain_valid}, 2'b10);
  endtask

  initial begin
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=<150000", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!chain_valid && !done, "R1 in reset", {chain_valid, done}, 2'b00);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check(!chain_valid && !done, "R1 idle after reset", {chain_valid, done}, 2'b00);
    // R2: first vector is seed with zero Johnson state
    @(negedge clk); start = 1; test_len = 16'd3; chain_ready = 0;
    @(negedge clk); start = 0;
    check(chain_valid && chain_data == fanout(SEED0, '0), "R2 first vector",
          64'(chain_data), 64'(fanout(SEED0, '0)));
    chain_ready = 1;
    @(negedge clk);
    check(chain_data == fanout(SEED0, 8'h01), "R3 one Johnson step",
          64'(chain_data), 64'(fanout(SEED0, 8'h01)));
    repeat (3) @(negedge clk);
    check(done && !chain_valid, "R8 short run done", {done, chain_valid}, 2'b10);
    // R9: zero length
    start = 1; test_len = 16'd0;
    @(negedge clk); start = 0;
    check(done && !chain_valid, "R9 zero length", {done, chain_valid}, 2'b10);
    // Table walk; each rerun starts from the initial seed (R11)
    for (int c = 0; c < NCASE; c++)
      run_case(int'(CASES[c][31:16]), CASES[c][15:8], int'(CASES[c][7:0]));
    run_case(40, 8'hFF, 0); // R11 repeat of first case
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule